// File: doc/BRIEF.md
# Dual-Mode Up Counter with Byte-Scanned Snapshot Readout

This block counts falling edges on asynchronous pulse inputs. It works either as one wide binary up counter or as two independent half-width up counters. All of its pins are sampled with a system clock through a synchronizer, and edges are found on the synchronized levels. A test pulse input lets the upper half be advanced on its own in single mode, but only while the lowest bit of that half is zero.

A snapshot register follows the counter value, together with an 8-bit byte from an external prescaler, while the active-low load pin is held low. It freezes when that pin is released. The most significant bit of the prescaler byte is the count A pin itself.

The snapshot is read out one byte per scan clock over an 8-bit data bus that has a separate output-enable. A scan reset points back at the first byte. Once every byte has been presented, a cascade output rises so that it can enable the next block on a shared bus.

Top module: `byte_scan_counter`

## Requirements
- R1: In single mode (dual_mode = 0), each falling edge of cnt_a raises the full 2*HALF_W-bit count by one, and the low half carries into the high half.
- R2: In dual mode (dual_mode = 1), cnt_a falling edges advance the low HALF_W bits, and cnt_b falling edges advance the high HALF_W bits. The low half never carries into the high half. In single mode cnt_b has no effect.
- R3: While clr_n is low the whole count is zero. Edges on cnt_a or cnt_b that arrive while clr_n is low are not counted.
- R4: In single mode, a falling edge of test_cnt adds one to the high half only if count bit HALF_W (bit 16 by default) is 0. In dual mode test_cnt has no effect.
- R5: While load_n is low, the snapshot follows the current count and the prescaler byte. After load_n rises, the snapshot holds, and later counting does not change it.
- R6: Snapshot byte 0 is {cnt_a, ext_lo[6:0]}. Bit 7 of that byte is the level of cnt_a at load time.
- R7: Byte 0 is scanned first, followed by the count bytes from least to most significant. A high scan_rst selects byte 0, and each rising edge of scan_clk selects the next byte.
- R8: dout_oe is 1 only while scan_en is 1 and the pointer is on one of the 1 + 2*HALF_W/8 bytes. When dout_oe is 0, dout is 0.
- R9: cascade_out is 1 when scan_en is 1 and the pointer has moved past the last byte. Further scan_clk edges leave the pointer there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Active-low reset of synchronizers and state |
| dual_mode | input | 1 | 0: one wide counter, 1: two half counters |
| cnt_a | input | 1 | Count pulses (low half or whole counter); MSB of prescaler byte |
| cnt_b | input | 1 | Count pulses for the high half in dual mode |
| test_cnt | input | 1 | Test pulses for the high half in single mode |
| clr_n | input | 1 | Active-low counter clear |
| ext_lo | input | 7 | Lower seven bits of the external prescaler byte |
| load_n | input | 1 | Active-low snapshot transparent control |
| scan_clk | input | 1 | Rising edge advances the readout pointer |
| scan_rst | input | 1 | High returns the readout pointer to byte 0 |
| scan_en | input | 1 | Readout enable |
| dout | output | 8 | Selected snapshot byte, zero when not driven |
| dout_oe | output | 1 | Output-enable for dout |
| cascade_out | output | 1 | Readout finished; enables the next block |

## Verification
Several sets of pulse counts are applied in both modes. A short run in single mode checks plain counting. Runs of exactly 255 and 259 pulses separate a correct carry from a missing one. A 260-pulse run in dual mode shows that the low half wraps with no carry into the high half. Mixed runs on cnt_b and test_cnt show whether these inputs are routed by mode and whether the bit-16 gate on test_cnt works. A 0 in byte 0 against a 1 there tells whether cnt_a is really latched as the prescaler MSB. Counting after load_n rises separates a held snapshot from a transparent one.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } cnt_mode_e;

    function automatic int unsigned scan_bytes(input int unsigned half_w, input int unsigned byte_w);
        return 1 + (2 * half_w) / byte_w;
    endfunction
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
    parameter int          N       = 1,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/bsc_counter.sv
module bsc_counter
    import bsc_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode,
    input  logic             clr_n,
    input  logic             a_lvl,
    input  logic             b_lvl,
    input  logic             t_lvl,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
        logic              a_prev;
        logic              b_prev;
        logic              t_prev;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    logic            a_fall, b_fall, t_fall;
    logic [HALF_W:0] lo_sum;
    logic            lo_carry;
    logic            test_ok;
    logic            hi_step_a, hi_step_b;

    always_comb begin
        a_fall    = st_q.a_prev & ~a_lvl;
        b_fall    = st_q.b_prev & ~b_lvl;
        t_fall    = st_q.t_prev & ~t_lvl;
        lo_sum    = {1'b0, st_q.lo} + (HALF_W+1)'(a_fall);
        lo_carry  = lo_sum[HALF_W] & (mode == MODE_SINGLE);
        test_ok   = t_fall & ~st_q.hi[0] & (mode == MODE_SINGLE);
        hi_step_a = (mode == MODE_DUAL) ? b_fall : lo_carry;
        hi_step_b = test_ok;

        st_d        = st_q;
        st_d.a_prev = a_lvl;
        st_d.b_prev = b_lvl;
        st_d.t_prev = t_lvl;
        if (!clr_n) begin
            st_d.lo = '0;
            st_d.hi = '0;
        end else begin
            st_d.lo = lo_sum[HALF_W-1:0];
            st_d.hi = st_q.hi + HALF_W'(hi_step_a) + HALF_W'(hi_step_b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = {st_q.hi, st_q.lo};

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> count_o == '0);

    p_single_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n && mode == MODE_SINGLE && a_fall && !t_fall
        |=> count_o == $past(count_o) + 1'b1);

    p_dual_hi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n && mode == MODE_DUAL && !b_fall
        |=> count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W]));

    p_test_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n && mode == MODE_SINGLE && !a_fall && count_o[HALF_W]
        |=> count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W]));
endmodule

// File: rtl/bsc_scan.sv
module bsc_scan
    import bsc_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int BYTE_W = 8,
    localparam int CNT_W  = 2 * HALF_W,
    localparam int NBYTES = scan_bytes(HALF_W, BYTE_W),
    localparam int PTR_W  = $clog2(NBYTES + 1),
    localparam int SNAP_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [BYTE_W-1:0] ext_byte,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              sclk_lvl,
    input  logic              srst_lvl,
    input  logic              en_lvl,
    output logic [BYTE_W-1:0] dout_o,
    output logic              oe_o,
    output logic              cascade_o
);
    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] snap;
        logic [PTR_W-1:0]              ptr;
        logic                          sclk_prev;
    } scan_state_t;

    scan_state_t st_d, st_q;

    logic             sclk_rise;
    logic             in_range;
    logic [PTR_W-1:0] sel;

    always_comb begin
        sclk_rise      = sclk_lvl & ~st_q.sclk_prev;
        st_d           = st_q;
        st_d.sclk_prev = sclk_lvl;
        if (!load_n) begin
            st_d.snap = SNAP_W'({count_i, ext_byte});
        end
        if (srst_lvl) begin
            st_d.ptr = '0;
        end else if (sclk_rise && (st_q.ptr < PTR_W'(NBYTES))) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        in_range  = st_q.ptr < PTR_W'(NBYTES);
        oe_o      = en_lvl & in_range;
        cascade_o = en_lvl & (st_q.ptr == PTR_W'(NBYTES));
        sel       = in_range ? st_q.ptr : '0;
        dout_o    = oe_o ? st_q.snap[sel] : '0;
    end

    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> dout_o == '0);

    p_cascade_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_o |-> !oe_o);

    p_scan_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        srst_lvl |=> st_q.ptr == '0);

    p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_n && $past(load_n) |-> $stable(st_q.snap));
endmodule

// File: rtl/byte_scan_counter.sv
module byte_scan_counter
    import bsc_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_mode,
    input  logic              cnt_a,
    input  logic              cnt_b,
    input  logic              test_cnt,
    input  logic              clr_n,
    input  logic [BYTE_W-2:0] ext_lo,
    input  logic              load_n,
    input  logic              scan_clk,
    input  logic              scan_rst,
    input  logic              scan_en,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_oe,
    output logic              cascade_out
);
    localparam int CNT_W    = 2 * HALF_W;
    localparam int I_A      = 0;
    localparam int I_B      = 1;
    localparam int I_T      = 2;
    localparam int I_CLR    = 3;
    localparam int I_LOAD   = 4;
    localparam int I_SCLK   = 5;
    localparam int I_SRST   = 6;
    localparam int I_SEN    = 7;
    localparam int I_EXT    = 8;
    localparam int N_SYNC   = I_EXT + BYTE_W - 1;
    localparam logic [N_SYNC-1:0] SYNC_RST = N_SYNC'(1) << I_LOAD;

    logic [N_SYNC-1:0] raw_in, lvl;
    logic [CNT_W-1:0]  count;
    logic [BYTE_W-1:0] ext_byte;
    cnt_mode_e         mode;

    assign raw_in = {ext_lo, scan_en, scan_rst, scan_clk, load_n, clr_n, test_cnt, cnt_b, cnt_a};
    assign mode   = dual_mode ? MODE_DUAL : MODE_SINGLE;

    bsc_sync #(
        .N       (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .level_o (lvl)
    );

    bsc_counter #(
        .HALF_W (HALF_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .clr_n   (lvl[I_CLR]),
        .a_lvl   (lvl[I_A]),
        .b_lvl   (lvl[I_B]),
        .t_lvl   (lvl[I_T]),
        .count_o (count)
    );

    assign ext_byte = {lvl[I_A], lvl[N_SYNC-1:I_EXT]};

    bsc_scan #(
        .HALF_W (HALF_W),
        .BYTE_W (BYTE_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (lvl[I_LOAD]),
        .ext_byte  (ext_byte),
        .count_i   (count),
        .sclk_lvl  (lvl[I_SCLK]),
        .srst_lvl  (lvl[I_SRST]),
        .en_lvl    (lvl[I_SEN]),
        .dout_o    (dout),
        .oe_o      (dout_oe),
        .cascade_o (cascade_out)
    );
endmodule

// File: tb/byte_scan_counter_test.sv
module byte_scan_counter_test;
    localparam int HW = 8;
    localparam int NB = 1 + (2 * HW) / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dual_mode = 1'b0;
    logic cnt_a = 1'b1, cnt_b = 1'b0, test_cnt = 1'b0;
    logic clr_n = 1'b1;
    logic [6:0] ext_lo = '0;
    logic load_n = 1'b1, scan_clk = 1'b0, scan_rst = 1'b0, scan_en = 1'b0;
    logic [7:0] dout;
    logic dout_oe, cascade_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    byte_scan_counter #(.HALF_W(HW), .BYTE_W(8), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .test_cnt(test_cnt), .clr_n(clr_n),
        .ext_lo(ext_lo), .load_n(load_n), .scan_clk(scan_clk),
        .scan_rst(scan_rst), .scan_en(scan_en),
        .dout(dout), .dout_oe(dout_oe), .cascade_out(cascade_out)
    );

    // columns: mode, A pulses, B pulses, test pulses, expected count
    localparam int NV = 9;
    localparam int VEC [NV][5] = '{
        '{0,   5, 0, 0, 5},
        '{0, 255, 0, 0, 255},
        '{0, 259, 0, 0, 259},
        '{1, 260, 0, 0, 4},
        '{1,   3, 7, 0, 'h0703},
        '{0,   0, 0, 3, 'h0100},
        '{0,   1, 0, 2, 'h0101},
        '{1,   2, 0, 5, 2},
        '{0,   0, 4, 0, 0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        case (which)
            0: cnt_a = 1'b0;
            1: cnt_b = 1'b1;
            default: test_cnt = 1'b1;
        endcase
        wait_n(3);
        case (which)
            0: cnt_a = 1'b1;
            1: cnt_b = 1'b0;
            default: test_cnt = 1'b0;
        endcase
        wait_n(3);
        if (which == 1) begin
            cnt_b = 1'b0;
        end
    endtask

    // B idles low, so a falling edge is high then low
    task automatic pulse_b();
        cnt_b = 1'b1; wait_n(3); cnt_b = 1'b0; wait_n(3);
    endtask

    task automatic pulse_t();
        test_cnt = 1'b1; wait_n(3); test_cnt = 1'b0; wait_n(3);
    endtask

    task automatic do_clear();
        clr_n = 1'b0; wait_n(4); clr_n = 1'b1; wait_n(4);
    endtask

    task automatic do_load();
        load_n = 1'b0; wait_n(4); load_n = 1'b1; wait_n(4);
    endtask

    task automatic scan_restart();
        scan_rst = 1'b1; wait_n(4); scan_rst = 1'b0; wait_n(4);
    endtask

    task automatic scan_step();
        scan_clk = 1'b1; wait_n(3); scan_clk = 1'b0; wait_n(3);
    endtask

    task automatic scan_all(input string req, output logic [7:0] b0, output logic [15:0] cnt);
        logic [NB*8-1:0] v;
        v = '0;
        scan_restart();
        for (int i = 0; i < NB; i++) begin
            check({req, " R8 oe during scan"}, 64'(dout_oe), 64'd1);
            v[i*8 +: 8] = dout;
            scan_step();
        end
        check({req, " R9 cascade after last byte"}, 64'(cascade_out), 64'd1);
        b0  = v[7:0];
        cnt = v[NB*8-1:8];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b0;
        logic [15:0] cv;
        wait_n(3);
        // reset state, R8/R9
        check("R8 oe at reset", 64'(dout_oe), 64'd0);
        check("R8 dout at reset", 64'(dout), 64'd0);
        check("R9 cascade at reset", 64'(cascade_out), 64'd0);
        rst_n = 1'b1;
        wait_n(2);
        scan_en = 1'b1;
        wait_n(4);

        // vector table: R1 R2 R4 R6 R7
        for (int v = 0; v < NV; v++) begin
            dual_mode = VEC[v][0][0];
            ext_lo = 7'(7'h35 + v);
            do_clear();
            for (int k = 0; k < VEC[v][1]; k++) pulse(0);
            for (int k = 0; k < VEC[v][2]; k++) pulse_b();
            for (int k = 0; k < VEC[v][3]; k++) pulse_t();
            do_load();
            scan_all("R7 vector", b0, cv);
            check($sformatf("R1 R2 R4 vector %0d count", v), 64'(cv), 64'(VEC[v][4]));
            check($sformatf("R6 vector %0d byte0", v), 64'(b0), 64'({1'b1, 7'(7'h35 + v)}));
        end

        // R5: snapshot holds after load_n rises
        dual_mode = 1'b0;
        ext_lo = 7'h12;
        do_clear();
        for (int k = 0; k < 3; k++) pulse(0);
        do_load();
        pulse(0); pulse(0);
        scan_all("R5", b0, cv);
        check("R5 held snapshot", 64'(cv), 64'd3);
        do_load();
        scan_all("R5", b0, cv);
        check("R5 reloaded snapshot", 64'(cv), 64'd5);

        // R6: cnt_a low at load time is byte0 bit 7 (its fall counts once)
        cnt_a = 1'b0;
        wait_n(4);
        do_load();
        cnt_a = 1'b1;
        wait_n(4);
        scan_all("R6", b0, cv);
        check("R6 byte0 msb low", 64'(b0), 64'h12);
        check("R6 count with low A", 64'(cv), 64'd6);

        // R9: pointer saturates, cascade stays
        scan_step();
        check("R9 saturate cascade", 64'(cascade_out), 64'd1);
        check("R8 oe off past end", 64'(dout_oe), 64'd0);
        check("R8 dout zero past end", 64'(dout), 64'd0);
        scan_en = 1'b0;
        wait_n(4);
        check("R9 cascade needs enable", 64'(cascade_out), 64'd0);

        // R7: scan reset returns to byte 0; R8 enable gates
        scan_restart();
        check("R8 oe off with enable low", 64'(dout_oe), 64'd0);
        check("R8 dout zero with enable low", 64'(dout), 64'd0);
        scan_en = 1'b1;
        wait_n(4);
        check("R7 byte0 after scan reset", 64'(dout), 64'h12);
        check("R7 oe after scan reset", 64'(dout_oe), 64'd1);
        scan_step();
        check("R7 second byte is count LSB", 64'(dout), 64'd6);

        // R3: edges during clear are not counted
        dual_mode = 1'b1;
        clr_n = 1'b0;
        wait_n(4);
        pulse_b(); pulse_b(); pulse(0);
        clr_n = 1'b1;
        wait_n(4);
        do_load();
        scan_all("R3", b0, cv);
        check("R3 clear drops edges", 64'(cv), 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule